// File: doc/BRIEF.md
# Peripheral Idle Handshake Controller

This block sits inside a peripheral and decides when the peripheral may lose its clocks. It follows a three-signal handshake with the system power manager. The manager raises an idle request. The block answers with an idle acknowledge. While idle, the block can raise a wake-up request. A 2-bit policy input selects how the request is treated. Force-idle acknowledges it whatever the peripheral is doing. No-idle never acknowledges it. Smart-idle waits until no card transaction is in progress.

Separately from the handshake, the block autogates the interface and functional clock enables while it runs normally. Gating needs the autoidle bit set and a quiet card interface. A register access, a card interrupt or card activity reopens the clocks for a fixed hold window. A register access that arrives while the block is moving toward idle gets an error response one cycle later. The actual gating cells and the register decoding live outside the block.

Top module: `idle_hs_ctrl`

## Requirements
- R1: After reset, idle_ack_o, wakeup_o and reg_err_o are 0, and both clock enables are 1 while autoidle_i is 0.
- R2: With idle_mode_i = 0 (force), a held idle request raises idle_ack_o exactly 2 cycles after it is first sampled, even if card_busy_i is 1.
- R3: With idle_mode_i = 1 (no-idle), or the reserved value 3, the idle request has no effect: idle_ack_o stays 0 and the clock enables are unchanged.
- R4: With idle_mode_i = 2 (smart), idle_ack_o stays 0 while card_busy_i is 1. It rises one cycle after card_busy_i is first sampled 0 during the transition.
- R5: While idle_ack_o is 1, iclk_en_o and fclk_en_o are both 0, whatever clk_activity_i holds.
- R6: In normal mode with autoidle_i = 1 and no wake event, both enables are gated. In that case clk_activity_i bit 0 = 1 keeps iclk_en_o at 1, and bit 1 = 1 keeps fclk_en_o at 1.
- R7: A wake event is a register access, a card interrupt or card_busy_i = 1. It opens both enables from the next cycle. They stay open for WAKE_HOLD further cycles after the last event before gating resumes.
- R8: With autoidle_i = 0, the enables are never gated in normal mode.
- R9: A register access sampled during the normal-to-idle transition (request accepted, acknowledge not yet given) gives reg_err_o = 1 in the next cycle. An access in normal mode gives reg_err_o = 0.
- R10: A card interrupt sampled while idle_ack_o is 1 sets wakeup_o in the next cycle. wakeup_o then holds until the request drops.
- R11: When idle_req_i is sampled 0 while idle, idle_ack_o and wakeup_o both return to 0 in the next cycle, and the block is back in normal mode.
- R12: If idle_mode_i changes to no-idle during the transition, the transition is abandoned. idle_ack_o stays 0 and later accesses get no error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| idle_mode_i | input | 2 | Idle policy: 0 force, 1 no-idle, 2 smart, 3 treated as no-idle |
| autoidle_i | input | 1 | Enables clock autogating in normal mode |
| clk_activity_i | input | 2 | Bit 0 keeps the interface clock and bit 1 keeps the functional clock during autogating |
| reg_acc_i | input | 1 | Register access strobe |
| card_busy_i | input | 1 | Card-interface transaction in progress |
| card_irq_i | input | 1 | Card interrupt (wake event) |
| idle_req_i | input | 1 | Idle request from the power manager |
| idle_ack_o | output | 1 | Idle acknowledge; 1 means the peripheral is in idle mode |
| wakeup_o | output | 1 | Wake-up request to the power manager |
| iclk_en_o | output | 1 | Interface clock enable |
| fclk_en_o | output | 1 | Functional clock enable |
| reg_err_o | output | 1 | Error response for the access sampled in the previous cycle |

## Verification
The handshake state, the wake-up flag, the error response and the gate flag each sit behind one register. So the acknowledge comes 2 cycles after a forced request, and 1 cycle after busy falls in smart mode. Wake-up and error appear 1 cycle after their cause. Gating resumes WAKE_HOLD+1 cycles after the last wake event. The enables are a combinational function of those registers and clk_activity_i. The bench sweeps every idle-mode value and every activity setting. It changes inputs 1 ns after a rising edge and compares the outputs just after the edge at which each result is due. For every gating window it checks each intermediate cycle, not only the endpoint.

// File: rtl/idle_hs_pkg.sv
package idle_hs_pkg;
  typedef enum logic [1:0] {
    ST_NORMAL = 2'd0,
    ST_ENTER  = 2'd1,
    ST_IDLE   = 2'd2
  } hs_state_e;

  localparam logic [1:0] MODE_FORCE = 2'd0;
  localparam logic [1:0] MODE_NONE  = 2'd1;
  localparam logic [1:0] MODE_SMART = 2'd2;
endpackage

// File: rtl/idle_hs_fsm.sv
module idle_hs_fsm
  import idle_hs_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] mode_i,
  input  logic       idle_req_i,
  input  logic       card_busy_i,
  input  logic       card_irq_i,
  input  logic       reg_acc_i,
  output hs_state_e  state_o,
  output logic       wakeup_o,
  output logic       reg_err_o
);
  hs_state_e state_q, state_d;
  logic      wake_q, err_q;
  logic      want_idle, may_ack;

  // reserved code 3 falls through to no-idle
  assign want_idle = (mode_i == MODE_FORCE) || (mode_i == MODE_SMART);
  assign may_ack   = (mode_i == MODE_FORCE) || ((mode_i == MODE_SMART) && !card_busy_i);

  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_NORMAL: if (idle_req_i && want_idle) state_d = ST_ENTER;
      ST_ENTER: begin
        if (!idle_req_i || !want_idle) state_d = ST_NORMAL;
        else if (may_ack)              state_d = ST_IDLE;
      end
      ST_IDLE:   if (!idle_req_i) state_d = ST_NORMAL;
      default:   state_d = ST_NORMAL;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_NORMAL;
      wake_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      wake_q  <= (state_q == ST_IDLE) && idle_req_i && (wake_q || card_irq_i);
      err_q   <= reg_acc_i && (state_q == ST_ENTER);
    end
  end

  assign state_o   = state_q;
  assign wakeup_o  = wake_q;
  assign reg_err_o = err_q;
endmodule

// File: rtl/idle_hs_autogate.sv
module idle_hs_autogate #(
  parameter int unsigned WAKE_HOLD = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic normal_i,
  input  logic autoidle_i,
  input  logic wake_evt_i,
  output logic gate_o
);
  localparam int unsigned HW = $clog2(WAKE_HOLD + 1);
  localparam logic [HW-1:0] HOLD_V = HW'(WAKE_HOLD);

  logic [HW-1:0] hold_q;
  logic          gate_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
      gate_q <= 1'b0;
    end else begin
      if (wake_evt_i)       hold_q <= HOLD_V;
      else if (hold_q != 0) hold_q <= hold_q - 1'b1;
      gate_q <= normal_i && autoidle_i && !wake_evt_i && (hold_q == 0);
    end
  end

  assign gate_o = gate_q;
endmodule

// File: rtl/idle_hs_ctrl.sv
module idle_hs_ctrl
  import idle_hs_pkg::*;
#(
  parameter int unsigned WAKE_HOLD = 4
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [1:0] idle_mode_i,
  input  logic       autoidle_i,
  input  logic [1:0] clk_activity_i,
  input  logic       reg_acc_i,
  input  logic       card_busy_i,
  input  logic       card_irq_i,
  input  logic       idle_req_i,
  output logic       idle_ack_o,
  output logic       wakeup_o,
  output logic       iclk_en_o,
  output logic       fclk_en_o,
  output logic       reg_err_o
);
  hs_state_e state;
  logic      gate, in_idle;

  idle_hs_fsm u_fsm (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .mode_i      (idle_mode_i),
    .idle_req_i  (idle_req_i),
    .card_busy_i (card_busy_i),
    .card_irq_i  (card_irq_i),
    .reg_acc_i   (reg_acc_i),
    .state_o     (state),
    .wakeup_o    (wakeup_o),
    .reg_err_o   (reg_err_o)
  );

  idle_hs_autogate #(.WAKE_HOLD(WAKE_HOLD)) u_gate (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .normal_i   (state == ST_NORMAL),
    .autoidle_i (autoidle_i),
    .wake_evt_i (reg_acc_i || card_irq_i || card_busy_i),
    .gate_o     (gate)
  );

  assign in_idle    = (state == ST_IDLE);
  assign idle_ack_o = in_idle;
  // idle overrides the activity field
  assign iclk_en_o  = !in_idle && !(gate && !clk_activity_i[0]);
  assign fclk_en_o  = !in_idle && !(gate && !clk_activity_i[1]);
endmodule

// File: rtl/idle_hs_chk.sv
module idle_hs_chk #(
  parameter int unsigned WAKE_HOLD = 4
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [1:0] idle_mode_i,
  input logic       autoidle_i,
  input logic [1:0] clk_activity_i,
  input logic       reg_acc_i,
  input logic       card_busy_i,
  input logic       card_irq_i,
  input logic       idle_req_i,
  input logic       idle_ack_o,
  input logic       wakeup_o,
  input logic       iclk_en_o,
  input logic       fclk_en_o,
  input logic       reg_err_o
);
  localparam int unsigned CW = $clog2(WAKE_HOLD + 2) + 1;
  localparam logic [CW-1:0] CMAX = CW'(WAKE_HOLD + 1);

  logic [CW-1:0] since_evt;
  logic          evt;
  assign evt = reg_acc_i || card_irq_i || card_busy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)              since_evt <= CMAX;
    else if (evt)             since_evt <= '0;
    else if (since_evt != CMAX) since_evt <= since_evt + 1'b1;
  end

  a_r3_no_ack_in_noidle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(idle_ack_o) |-> ($past(idle_mode_i) == 2'd0 || $past(idle_mode_i) == 2'd2));

  a_r4_smart_waits_busy: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ($rose(idle_ack_o) && $past(idle_mode_i) == 2'd2) |-> !$past(card_busy_i));

  a_r5_idle_clocks_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    idle_ack_o |-> (!iclk_en_o && !fclk_en_o));

  a_r7_hold_window: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((since_evt < CMAX) && !idle_ack_o) |-> (iclk_en_o && fclk_en_o));

  a_r9_err_needs_access: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_err_o |-> $past(reg_acc_i));

  a_r10_wakeup_only_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wakeup_o |-> idle_ack_o);

  a_r11_release: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (idle_ack_o && !idle_req_i) |=> (!idle_ack_o && !wakeup_o));
endmodule

bind idle_hs_ctrl idle_hs_chk #(.WAKE_HOLD(WAKE_HOLD)) u_chk (.*);

// File: tb/tb_idle_hs_ctrl.sv
`timescale 1ns/1ps
module tb_idle_hs_ctrl;
  localparam int unsigned HOLD = 4;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [1:0] mode = 2'd1;
  logic       autoidle = 1'b0;
  logic [1:0] act = 2'd0;
  logic       acc = 1'b0, busy = 1'b0, irq = 1'b0, req = 1'b0;
  logic       ack, wake, ien, fen, err;
  int         total = 0, bad = 0;
  bit         done = 1'b0;

  always #2.5 clk = ~clk;

  idle_hs_ctrl #(.WAKE_HOLD(HOLD)) dut (
    .clk_i(clk), .rst_ni(rst_n), .idle_mode_i(mode), .autoidle_i(autoidle),
    .clk_activity_i(act), .reg_acc_i(acc), .card_busy_i(busy), .card_irq_i(irq),
    .idle_req_i(req), .idle_ack_o(ack), .wakeup_o(wake), .iclk_en_o(ien),
    .fclk_en_o(fen), .reg_err_o(err)
  );

  task automatic tick();
    @(posedge clk); #1;
  endtask

  task automatic chk(string tag, logic got, logic exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s got=%b exp=%b at %0t", tag, got, exp, $time);
    end
  endtask

  task automatic to_normal();
    req = 0; busy = 0; irq = 0; acc = 0; tick(); tick();
  endtask

  initial begin
    #200000;
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog expired");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    #7; rst_n = 1'b1; tick();
    // R1 reset state
    chk("R1 ack", ack, 0); chk("R1 wake", wake, 0); chk("R1 err", err, 0);
    chk("R1 ien", ien, 1); chk("R1 fen", fen, 1);

    // R2/R3/R4 sweep over all mode codes, idle card
    for (int m = 0; m < 4; m++) begin
      logic accepts;
      accepts = (m == 0) || (m == 2);
      mode = 2'(m); req = 1; tick();
      chk("R2/R3 ack after 1", ack, 0);
      tick();
      chk(accepts ? "R2/R4 ack after 2" : "R3 no ack", ack, accepts);
      chk(accepts ? "R5 ien idle" : "R3 ien", ien, !accepts);
      to_normal();
      chk("R11 ack cleared", ack, 0);
    end

    // R2 force ignores busy
    mode = 0; busy = 1; req = 1; tick(); tick();
    chk("R2 force busy", ack, 1);
    to_normal();

    // R4 + R9 smart waits on busy, access in transition errs
    mode = 2; busy = 1; req = 1; tick();
    for (int i = 0; i < 5; i++) begin
      acc = (i == 2); tick();
      chk("R4 busy holds", ack, 0);
      chk("R9 err", err, (i == 2));
    end
    busy = 0; tick();
    chk("R4 ack after busy drop", ack, 1);

    // R5 every activity setting while idle
    for (int a = 0; a < 4; a++) begin
      act = 2'(a); #1;
      chk("R5 ien", ien, 0); chk("R5 fen", fen, 0);
    end
    act = 0;

    // R10 wakeup sticky, R11 release
    irq = 1; tick(); chk("R10 wake", wake, 1);
    irq = 0; tick(); chk("R10 wake holds", wake, 1);
    req = 0; tick();
    chk("R11 ack", ack, 0); chk("R11 wake", wake, 0);
    tick();

    // R9 no error in normal mode
    acc = 1; tick(); acc = 0; chk("R9 normal no err", err, 0);

    // R12 abort transition
    mode = 2; busy = 1; req = 1; tick(); tick();
    mode = 1; tick();
    busy = 0; acc = 1; tick(); acc = 0;
    chk("R12 no err", err, 0); tick();
    chk("R12 no ack", ack, 0);
    to_normal(); mode = 1;

    // R8 no gating with autoidle off
    autoidle = 0;
    for (int i = 0; i < 8; i++) begin tick(); chk("R8 ien", ien, 1); end

    // R6 gating under each activity setting
    autoidle = 1;
    for (int a = 0; a < 4; a++) begin
      act = 2'(a); tick(); tick();
      chk("R6 ien", ien, act[0]); chk("R6 fen", fen, act[1]);
    end
    act = 0;

    // R7 hold window after each event kind
    for (int e = 0; e < 3; e++) begin
      acc = (e == 0); irq = (e == 1); busy = (e == 2); tick();
      acc = 0; irq = 0; busy = 0;
      chk("R7 open", ien, 1);
      for (int i = 1; i <= int'(HOLD); i++) begin
        tick(); chk("R7 hold", fen, 1);
      end
      tick(); chk("R7 regated", ien, 0); chk("R7 regated f", fen, 0);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule